// File: doc/BRIEF.md
# Two-Key Register Write Unlock

This block guards the register file of a peripheral against stray writes. It sits between a 32-bit register-bus slave port and the protected registers. Every access that does not address one of its two key registers is handed through. Writes reach the protected registers only while both key registers hold their own fixed 32-bit magic word. A write to either key register is always accepted, and storing any other value in either key, zero included, locks the gate again.

Software opens the gate by writing the first magic word to one key and the second magic word to the other key. It then performs the guarded writes and closes the gate by writing zero to both keys. A write that arrives while the gate is closed finishes on the bus like any other access but is not forwarded, so it has no effect. Reads are never gated. A read of a key register returns the value that key holds, and every other read returns the protected side's read data unchanged. The protected registers themselves are outside this block.

Top module: `regwr_keygate`

## Requirements
- R1: After synchronous active-low reset both key registers read as 0 and the gate is closed, so a protected write is not forwarded.
- R2: The first key register is at byte address 0x6C and the second at 0x70. A write to either is always stored, whatever the lock state, and a later read of that address returns the stored value.
- R3: While the key at 0x6C holds 0x83E70B13 and the key at 0x70 holds 0x95A4F1E0, a write to any non-key address asserts prot_wr_en in the same cycle, with prot_addr and prot_wdata equal to the bus address and data. This starts from the cycle after the second correct key was written.
- R4: If only one key, or neither, holds its magic word, a write to a non-key address leaves prot_wr_en at 0.
- R5: Writing any value other than its magic word to either key closes the gate from the next cycle. This includes zero and any single-bit variation of the magic word. Rewriting the magic word reopens the gate.
- R6: A write to a key address never asserts prot_wr_en.
- R7: A read of a non-key address asserts prot_rd_en and returns prot_rd_data on bus_rdata in the same cycle, whether the gate is open or closed. A read of a key address leaves prot_rd_en at 0.
- R8: The order in which the two keys are written does not matter: writing the key at 0x70 first and the key at 0x6C second also opens the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access present this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data: the key value or the protected side's data |
| prot_rd_data | input | 32 | Read data from the protected registers |
| prot_wr_en | output | 1 | Write strobe toward the protected registers |
| prot_rd_en | output | 1 | Read strobe toward the protected registers |
| prot_addr | output | 8 | Address toward the protected registers |
| prot_wdata | output | 32 | Write data toward the protected registers |

## Verification
The assertions assume one access per cycle, with bus_write and bus_addr meaningful only while bus_valid is high, and with key matching done on whole word addresses. The stimulus stays within these assumptions. It drives only word-aligned addresses, holds each access for exactly one cycle, and sets prot_rd_data from the address so that a passed-through read can be told apart. It sweeps every word address under all four combinations of correct and incorrect keys and flips each bit of both magic words in turn.

// File: rtl/keygate_pkg.sv
// Shared constants for the two-key write gate: bus widths, key
// locations and key magic words.
package keygate_pkg;
    localparam int unsigned KG_ADDR_W   = 8;
    localparam int unsigned KG_DATA_W   = 32;
    localparam int unsigned KG_NUM_KEYS = 2;

    localparam logic [KG_ADDR_W-1:0] KG_KEY0_OFF   = 8'h6C;
    localparam logic [KG_ADDR_W-1:0] KG_KEY1_OFF   = 8'h70;
    localparam logic [KG_DATA_W-1:0] KG_KEY0_MAGIC = 32'h83E7_0B13;
    localparam logic [KG_DATA_W-1:0] KG_KEY1_MAGIC = 32'h95A4_F1E0;

    // Kind of bus access this cycle
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;
endpackage

// File: rtl/keygate_decode.sv
// Address decoder: classifies the current bus access and marks which key
// register, if any, it addresses.
// Assumes one access per cycle and exact address compare.
module keygate_decode
    import keygate_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_KEYS = 2,
    parameter logic [NUM_KEYS*ADDR_W-1:0] KEY_OFFS = '0
) (
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    output acc_kind_t           acc_kind,
    output logic [NUM_KEYS-1:0] key_hit,
    output logic                any_key
);
    // Per-key address match
    for (genvar i = 0; i < NUM_KEYS; i++) begin : g_hit
        assign key_hit[i] = (bus_addr == KEY_OFFS[i*ADDR_W +: ADDR_W]);
    end

    assign any_key = |key_hit;

    // Access kind from the valid and direction bits
    always_comb begin
        if (!bus_valid)
            acc_kind = ACC_IDLE;
        else if (bus_write)
            acc_kind = ACC_WRITE;
        else
            acc_kind = ACC_READ;
    end
endmodule

// File: rtl/keygate_keyreg.sv
// One key register. It stores every word written to it and keeps a
// registered flag saying whether the stored word equals its magic value.
// Assumes wr is a single-cycle strobe.
module keygate_keyreg #(
    parameter int unsigned    DATA_W = 32,
    parameter logic [DATA_W-1:0] MAGIC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value_q,
    output logic              match_q
);
    // Capture the written key and precompute its match flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
            match_q <= 1'b0;
        end else if (wr) begin
            value_q <= wdata;
            match_q <= (wdata == MAGIC);
        end
    end
endmodule

// File: rtl/keygate_route.sv
// Access router: gates writes toward the protected registers, forwards
// reads and selects the read data.
// Assumes key_hit is one-hot or zero.
module keygate_route
    import keygate_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_KEYS = 2
) (
    input  acc_kind_t                   acc_kind,
    input  logic [NUM_KEYS-1:0]         key_hit,
    input  logic                        any_key,
    input  logic                        gate_open,
    input  logic [NUM_KEYS*DATA_W-1:0]  key_flat,
    input  logic [DATA_W-1:0]           prot_rd_data,
    output logic                        prot_wr_en,
    output logic                        prot_rd_en,
    output logic [DATA_W-1:0]           bus_rdata
);
    // Strobes toward the protected side; key accesses stay local
    always_comb begin
        prot_wr_en = (acc_kind == ACC_WRITE) && !any_key && gate_open;
        prot_rd_en = (acc_kind == ACC_READ) && !any_key;
    end

    // Read data: the addressed key's value or the protected side's data
    always_comb begin
        bus_rdata = any_key ? '0 : prot_rd_data;
        for (int i = 0; i < NUM_KEYS; i++) begin
            if (key_hit[i])
                bus_rdata = key_flat[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/regwr_keygate.sv
// Two-key write unlock gate in front of a peripheral register file.
// Writes reach the protected registers only while every key holds its
// magic word. Key writes are always accepted and reads always pass.
// Assumes a single-cycle, always-ready register bus.
module regwr_keygate
    import keygate_pkg::*;
#(
    parameter int unsigned ADDR_W = KG_ADDR_W,
    parameter int unsigned DATA_W = KG_DATA_W,
    parameter logic [ADDR_W-1:0] KEY0_OFF   = KG_KEY0_OFF,
    parameter logic [ADDR_W-1:0] KEY1_OFF   = KG_KEY1_OFF,
    parameter logic [DATA_W-1:0] KEY0_MAGIC = KG_KEY0_MAGIC,
    parameter logic [DATA_W-1:0] KEY1_MAGIC = KG_KEY1_MAGIC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] prot_rd_data,
    output logic              prot_wr_en,
    output logic              prot_rd_en,
    output logic [ADDR_W-1:0] prot_addr,
    output logic [DATA_W-1:0] prot_wdata
);
    localparam int unsigned NUM_KEYS = KG_NUM_KEYS;
    localparam logic [NUM_KEYS*ADDR_W-1:0] KEY_OFFS   = {KEY1_OFF, KEY0_OFF};
    localparam logic [NUM_KEYS*DATA_W-1:0] KEY_MAGICS = {KEY1_MAGIC, KEY0_MAGIC};

    acc_kind_t                  acc_kind;
    logic [NUM_KEYS-1:0]        key_hit;
    logic                       any_key;
    logic [NUM_KEYS-1:0]        key_match;
    logic [NUM_KEYS*DATA_W-1:0] key_flat;
    logic                       gate_open;

    keygate_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_KEYS (NUM_KEYS),
        .KEY_OFFS (KEY_OFFS)
    ) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .acc_kind  (acc_kind),
        .key_hit   (key_hit),
        .any_key   (any_key)
    );

    // One key register per key slot
    for (genvar i = 0; i < NUM_KEYS; i++) begin : g_key
        keygate_keyreg #(
            .DATA_W (DATA_W),
            .MAGIC  (KEY_MAGICS[i*DATA_W +: DATA_W])
        ) u_key (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      ((acc_kind == ACC_WRITE) && key_hit[i]),
            .wdata   (bus_wdata),
            .value_q (key_flat[i*DATA_W +: DATA_W]),
            .match_q (key_match[i])
        );
    end

    // Gate is open only while every key matches
    assign gate_open = &key_match;

    keygate_route #(
        .DATA_W   (DATA_W),
        .NUM_KEYS (NUM_KEYS)
    ) u_route (
        .acc_kind     (acc_kind),
        .key_hit      (key_hit),
        .any_key      (any_key),
        .gate_open    (gate_open),
        .key_flat     (key_flat),
        .prot_rd_data (prot_rd_data),
        .prot_wr_en   (prot_wr_en),
        .prot_rd_en   (prot_rd_en),
        .bus_rdata    (bus_rdata)
    );

    // Address and data go straight through to the protected side
    assign prot_addr  = bus_addr;
    assign prot_wdata = bus_wdata;
endmodule

// File: rtl/keygate_checker.sv
// Property checker for regwr_keygate. It watches the bus ports, the
// protected-side strobes and the stored key values.
module keygate_checker #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] KEY0_OFF   = '0,
    parameter logic [ADDR_W-1:0] KEY1_OFF   = '0,
    parameter logic [DATA_W-1:0] KEY0_MAGIC = '0,
    parameter logic [DATA_W-1:0] KEY1_MAGIC = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] prot_rd_data,
    input logic              prot_wr_en,
    input logic              prot_rd_en,
    input logic [2*DATA_W-1:0] key_flat
);
    logic [DATA_W-1:0] k0;
    logic [DATA_W-1:0] k1;
    logic is_key;
    logic wr_acc;
    assign k0     = key_flat[DATA_W-1:0];
    assign k1     = key_flat[2*DATA_W-1:DATA_W];
    assign is_key = (bus_addr == KEY0_OFF) || (bus_addr == KEY1_OFF);
    assign wr_acc = bus_valid && bus_write;

    p_key0_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc && bus_addr == KEY0_OFF |=> k0 == $past(bus_wdata));
    p_key1_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc && bus_addr == KEY1_OFF |=> k1 == $past(bus_wdata));
    p_open_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc && !is_key && k0 == KEY0_MAGIC && k1 == KEY1_MAGIC |-> prot_wr_en);
    p_locked_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr_en |-> k0 == KEY0_MAGIC && k1 == KEY1_MAGIC);
    p_relock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc && ((bus_addr == KEY0_OFF && bus_wdata != KEY0_MAGIC) ||
                   (bus_addr == KEY1_OFF && bus_wdata != KEY1_MAGIC))
        |=> !prot_wr_en);
    p_key_no_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc && is_key |-> !prot_wr_en);
    p_read_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_write && !is_key |-> prot_rd_en && bus_rdata == prot_rd_data);
endmodule

bind regwr_keygate keygate_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .KEY0_OFF   (KEY0_OFF),
    .KEY1_OFF   (KEY1_OFF),
    .KEY0_MAGIC (KEY0_MAGIC),
    .KEY1_MAGIC (KEY1_MAGIC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .prot_rd_data (prot_rd_data),
    .prot_wr_en   (prot_wr_en),
    .prot_rd_en   (prot_rd_en),
    .key_flat     (key_flat)
);

// File: tb/tb_regwr_keygate.sv
// Self-checking bench for regwr_keygate: sweeps every word address under
// all key states and flips every bit of both magic words.
module tb_regwr_keygate;
    localparam logic [7:0]  K0A = 8'h6C;
    localparam logic [7:0]  K1A = 8'h70;
    localparam logic [31:0] M0  = 32'h83E7_0B13;
    localparam logic [31:0] M1  = 32'h95A4_F1E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] prot_rd_data = '0;
    logic        prot_wr_en;
    logic        prot_rd_en;
    logic [7:0]  prot_addr;
    logic [31:0] prot_wdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] mk0 = '0;
    logic [31:0] mk1 = '0;

    regwr_keygate dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prot_rd_data(prot_rd_data), .prot_wr_en(prot_wr_en),
        .prot_rd_en(prot_rd_en), .prot_addr(prot_addr), .prot_wdata(prot_wdata)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_pat(input logic [7:0] a);
        return {a, a ^ 8'h5A, 16'hC0DE};
    endfunction

    // One access between negedges; outputs sampled 2 ns after driving
    task automatic acc(input bit wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        prot_rd_data = rd_pat(a);
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // Key write: no forward (R6), model updated after
    task automatic key_wr(input logic [7:0] a, input logic [31:0] d);
        acc(1'b1, a, d);
        chk(prot_wr_en == 1'b0, "R6 key write not forwarded", {31'd0, prot_wr_en}, 32'd0);
        if (a == K0A) mk0 = d; else mk1 = d;
    endtask

    // Protected write with expected gating from the model
    task automatic prot_wr(input logic [7:0] a, input logic [31:0] d, input string req);
        bit open;
        open = (mk0 == M0) && (mk1 == M1);
        acc(1'b1, a, d);
        chk(prot_wr_en == open, req, {31'd0, prot_wr_en}, {31'd0, open});
        if (open)
            chk(prot_addr == a && prot_wdata == d, "R3 forwarded address/data",
                prot_wdata, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        acc(1'b0, K0A, '0);
        chk(bus_rdata == 32'd0, "R1 key0 reads 0 after reset", bus_rdata, 32'd0);
        acc(1'b0, K1A, '0);
        chk(bus_rdata == 32'd0, "R1 key1 reads 0 after reset", bus_rdata, 32'd0);
        acc(1'b1, 8'h60, 32'h1234_5678);
        chk(prot_wr_en == 1'b0, "R1 protected write blocked after reset",
            {31'd0, prot_wr_en}, 32'd0);

        // R3/R4/R7/R8: all key states, both write orders, every word address
        for (int pass = 0; pass < 2; pass++) begin
            for (int s = 0; s < 4; s++) begin
                if (pass == 1) begin
                    key_wr(K1A, s[1] ? M1 : 32'd0);
                    key_wr(K0A, s[0] ? M0 : 32'd0);
                end else begin
                    key_wr(K0A, s[0] ? M0 : 32'h0000_0001);
                    key_wr(K1A, s[1] ? M1 : 32'hFFFF_FFFF);
                end
                // R2: readback
                acc(1'b0, K0A, '0);
                chk(bus_rdata == mk0, "R2 key0 readback", bus_rdata, mk0);
                chk(prot_rd_en == 1'b0, "R7 key read stays local", {31'd0, prot_rd_en}, 32'd0);
                acc(1'b0, K1A, '0);
                chk(bus_rdata == mk1, "R2 key1 readback", bus_rdata, mk1);
                for (int w = 0; w < 64; w++) begin
                    logic [7:0] a;
                    a = 8'(w * 4);
                    if (a == K0A || a == K1A) continue;
                    prot_wr(a, {a, 24'hA5_0000} ^ 32'(s), (s == 3) ?
                        ((pass == 1) ? "R8 reverse-order unlock forwards" : "R3 unlocked write forwarded")
                        : "R4 partial key blocks write");
                    acc(1'b0, a, '0);
                    chk(prot_rd_en == 1'b1, "R7 read strobe", {31'd0, prot_rd_en}, 32'd1);
                    chk(bus_rdata == rd_pat(a), "R7 read data passes", bus_rdata, rd_pat(a));
                end
            end
        end

        // R5: every single-bit corruption of each key relocks; magic reopens
        key_wr(K0A, M0);
        key_wr(K1A, M1);
        for (int k = 0; k < 2; k++) begin
            for (int b = 0; b < 32; b++) begin
                logic [31:0] bad;
                bad = (k == 0 ? M0 : M1) ^ (32'd1 << b);
                key_wr(k == 0 ? K0A : K1A, bad);
                prot_wr(8'h64, 32'(b), "R5 corrupted key relocks");
                key_wr(k == 0 ? K0A : K1A, k == 0 ? M0 : M1);
                prot_wr(8'h68, 32'(b + 100), "R5 magic rewrite reopens");
            end
        end
        // R5: writing zero to one key relocks immediately
        key_wr(K1A, 32'd0);
        prot_wr(8'h00, 32'hDEAD_BEEF, "R5 zero relock");
        chk(prot_wr_en == 1'b0, "R5 zero relock blocks", {31'd0, prot_wr_en}, 32'd0);

        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule